// File: doc/BRIEF.md
# Large-Immediate Unfold Stage

This stage sits in a binary-translation pipeline between the decoder and the later mapping stages. It accepts one decoded source word at a time: an immediate-form arithmetic or logic operation, an upper-immediate load, or a memory load or store, each with a 16-bit immediate. It extends that immediate the way the source architecture does, then checks whether the result fits the target's signed 12-bit immediate field. A word that fits leaves as one target word. A word that does not fit is rewritten as a short sequence. The sequence builds the constant in a reserved temporary register and then performs the operation in register form, or uses the temporary as the base of the memory access.

Both sides are valid/ready streams. An input word transfers on a clock edge where `in_valid` and `in_ready` are both high. An output word transfers on a clock edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, every output field holds its value. The stage emits at most one target word per cycle. It holds `in_ready` low until the final word of the current group is being taken, so the stages upstream stall for as long as an expansion runs. Without back-pressure, single-word groups stream at one word per cycle.

The number of the temporary register comes from a configuration input and is captured when each word is accepted. The source operand registers are assumed never to name the temporary.

Top module: `imm_unfold`

## Requirements
- R1: While reset is active and after it is released, `out_valid` is 0 and `in_ready` is 1 until the first word is accepted.
- R2: Source op codes are ADDI=0, ADDIU=1, SLTI=2, SLTIU=3, ANDI=4, ORI=5, XORI=6, LUI=7, LOAD=8, STORE=9. Codes 4, 5 and 6 zero-extend the immediate to 32 bits, and all others sign-extend it. An extended value in -2048..2047 produces a single word with `out_last`=1. Target op codes are LUI=0, ADDI=1, SLTI=2, SLTIU=3, ANDI=4, ORI=5, XORI=6, ADD=7, SLT=8, SLTU=9, AND=10, OR=11, XOR=12, LOAD=13, STORE=14. The single word is ADDI/ADDIU→1, SLTI→2, SLTIU→3, ANDI→4, ORI→5, XORI→6 with rd=rt, rs1=rs, rs2=0, imm=extended value. A load gives 13 with rd=rt, rs1=rs. A store gives 14 with rd=0, rs1=rs, rs2=rt. All unused fields are 0.
- R3: A source LUI always passes as a single target LUI (code 0) with rd=rt, and imm equal to the 16-bit immediate shifted left by 4 (a 20-bit upper value).
- R4: When an immediate does not fit, it is split as hi = (value + 0x800) >> 12, taken as 20 bits, and lo = value − (hi << 12), a signed 12-bit value.
- R5: An arithmetic or logic op that does not fit emits, in order: LUI rd=tmp imm=hi. Then, only if lo is nonzero, ADDI rd=tmp rs1=tmp imm=lo. Then the register form (ADDI/ADDIU→7, SLTI→8, SLTIU→9, ANDI→10, ORI→11, XORI→12) with rd=rt, rs1=rs, rs2=tmp, imm=0.
- R6: A load or store that does not fit emits three words: LUI rd=tmp imm=hi, then ADD rd=tmp rs1=tmp rs2=rs, then the access with rs1=tmp and imm=lo. The access has rd=rt for a load, or rs2=rt for a store.
- R7: Every emitted word with an immediate-form op (codes 1..6, 13, 14) carries an imm in -2048..2047, and every emitted LUI carries an imm below 2^20.
- R8: Every word of a group carries the source PC of its input, and only the final word of a group has `out_last` set.
- R9: Output fields stay stable while `out_valid` is high and `out_ready` is low. `in_ready` is low whenever the word on the output is not the final word of its group.
- R10: The temporary register number is sampled from `cfg_tmp_reg` when the input word is accepted. Later changes do not affect a group already in progress.
- R11: Executing a group's words on a register model gives the same result as the source operation: the destination value for arithmetic and logic ops and LUI, and the effective address for loads and stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_tmp_reg | input | 5 | Number of the reserved temporary register |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Stage can accept an input word |
| in_pc | input | 32 | Source PC of the input word |
| in_op | input | 4 | Source op code (R2) |
| in_rs | input | 5 | Source base or operand register |
| in_rt | input | 5 | Source destination, or store data register |
| in_imm | input | 16 | Source immediate |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_pc | output | 32 | Source PC of the group |
| out_op | output | 4 | Target op code (R2) |
| out_rd | output | 5 | Target destination register |
| out_rs1 | output | 5 | Target first source register |
| out_rs2 | output | 5 | Target second source register |
| out_imm | output | 32 | Target immediate, or 20-bit upper value for LUI |
| out_last | output | 1 | Final word of the group |

## Verification
The immediates 0x7FFF, 0x8000, 0x0800, 0xF800, 0x07FF, 0xFFFF and 0 go through every op. Under zero extension and under sign extension they sit on opposite sides of the 12-bit limit. They also separate three-word from two-word expansions, since only some of them have a nonzero low part, and 0x0800 rounds the high part up. Random immediates and operands then cover the general case. Every emitted sequence runs on a register model and its result is compared with the source operation, which catches splitting and rounding errors that a field-only comparison could miss. Random stalls on `out_ready`, plus a change of the temporary register number in the middle of a group, test the hold and sampling rules.

// File: rtl/imm_unfold_pkg.sv
package imm_unfold_pkg;

  typedef enum logic [3:0] {
    SRC_ADDI  = 4'd0,
    SRC_ADDIU = 4'd1,
    SRC_SLTI  = 4'd2,
    SRC_SLTIU = 4'd3,
    SRC_ANDI  = 4'd4,
    SRC_ORI   = 4'd5,
    SRC_XORI  = 4'd6,
    SRC_LUI   = 4'd7,
    SRC_LOAD  = 4'd8,
    SRC_STORE = 4'd9
  } src_op_e;

  typedef enum logic [3:0] {
    TG_LUI   = 4'd0,
    TG_ADDI  = 4'd1,
    TG_SLTI  = 4'd2,
    TG_SLTIU = 4'd3,
    TG_ANDI  = 4'd4,
    TG_ORI   = 4'd5,
    TG_XORI  = 4'd6,
    TG_ADD   = 4'd7,
    TG_SLT   = 4'd8,
    TG_SLTU  = 4'd9,
    TG_AND   = 4'd10,
    TG_OR    = 4'd11,
    TG_XOR   = 4'd12,
    TG_LOAD  = 4'd13,
    TG_STORE = 4'd14
  } tgt_op_e;

  typedef enum logic [1:0] {
    STEP_PASS,
    STEP_UPPER,
    STEP_MID,
    STEP_FINAL
  } step_e;

  function automatic logic uses_zero_ext(input logic [3:0] s);
    return (s == SRC_ANDI) || (s == SRC_ORI) || (s == SRC_XORI);
  endfunction

  function automatic logic is_mem_op(input logic [3:0] s);
    return (s == SRC_LOAD) || (s == SRC_STORE);
  endfunction

  function automatic logic [3:0] imm_form(input logic [3:0] s);
    logic [3:0] t;
    case (s)
      SRC_SLTI:  t = TG_SLTI;
      SRC_SLTIU: t = TG_SLTIU;
      SRC_ANDI:  t = TG_ANDI;
      SRC_ORI:   t = TG_ORI;
      SRC_XORI:  t = TG_XORI;
      default:   t = TG_ADDI;
    endcase
    return t;
  endfunction

  function automatic logic [3:0] reg_form(input logic [3:0] s);
    logic [3:0] t;
    case (s)
      SRC_SLTI:  t = TG_SLT;
      SRC_SLTIU: t = TG_SLTU;
      SRC_ANDI:  t = TG_AND;
      SRC_ORI:   t = TG_OR;
      SRC_XORI:  t = TG_XOR;
      default:   t = TG_ADD;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/imm_ext_split.sv
module imm_ext_split
  import imm_unfold_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int SRC_IMM_W = 16,
  parameter int TGT_IMM_W = 12,
  parameter int HI_W      = XLEN - TGT_IMM_W
) (
  input  logic [3:0]           op,
  input  logic [SRC_IMM_W-1:0] imm,
  output logic [XLEN-1:0]      ext,
  output logic [HI_W-1:0]      hi,
  output logic [TGT_IMM_W-1:0] lo,
  output logic [1:0]           grp_len
);

  localparam logic [XLEN-1:0] ROUND = XLEN'(1) << (TGT_IMM_W - 1);

  logic [XLEN-1:0] rounded;
  logic            fits;
  logic            top_zero;
  logic            top_ones;

  always_comb begin
    if (uses_zero_ext(op)) begin
      ext = {{(XLEN-SRC_IMM_W){1'b0}}, imm};
    end else begin
      ext = {{(XLEN-SRC_IMM_W){imm[SRC_IMM_W-1]}}, imm};
    end
    rounded  = ext + ROUND;
    hi       = rounded[XLEN-1:TGT_IMM_W];
    lo       = ext[TGT_IMM_W-1:0];
    top_zero = ~(|ext[XLEN-1:TGT_IMM_W-1]);
    top_ones = &ext[XLEN-1:TGT_IMM_W-1];
    fits     = (op == SRC_LUI) || top_zero || top_ones;
    if (fits) begin
      grp_len = 2'd1;
    end else if (is_mem_op(op) || (lo != '0)) begin
      grp_len = 2'd3;
    end else begin
      grp_len = 2'd2;
    end
  end

endmodule

// File: rtl/imm_unfold_ctrl.sv
module imm_unfold_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       out_ready,
  input  logic [1:0] in_len,
  output logic       in_ready,
  output logic       take,
  output logic       busy,
  output logic [1:0] step,
  output logic [1:0] len,
  output logic       last
);

  always_comb begin
    last     = busy && (step == (len - 2'd1));
    in_ready = !busy || (out_ready && last);
    take     = in_valid && in_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      step <= 2'd0;
      len  <= 2'd1;
    end else if (take) begin
      busy <= 1'b1;
      step <= 2'd0;
      len  <= in_len;
    end else if (busy && out_ready) begin
      if (last) begin
        busy <= 1'b0;
      end else begin
        step <= step + 2'd1;
      end
    end
  end

  AST_STEP_IN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (step < len)); // R8

endmodule

// File: rtl/imm_word_gen.sv
module imm_word_gen
  import imm_unfold_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int REG_W     = 5,
  parameter int SRC_IMM_W = 16,
  parameter int TGT_IMM_W = 12,
  parameter int HI_W      = XLEN - TGT_IMM_W
) (
  input  logic [1:0]           step,
  input  logic [1:0]           len,
  input  logic [3:0]           src_op,
  input  logic [REG_W-1:0]     rs,
  input  logic [REG_W-1:0]     rt,
  input  logic [REG_W-1:0]     tmp,
  input  logic [XLEN-1:0]      ext,
  input  logic [HI_W-1:0]      hi,
  input  logic [TGT_IMM_W-1:0] lo,
  output logic [3:0]           op,
  output logic [REG_W-1:0]     rd,
  output logic [REG_W-1:0]     rs1,
  output logic [REG_W-1:0]     rs2,
  output logic [XLEN-1:0]      imm
);

  localparam int LUI_SH = SRC_IMM_W - TGT_IMM_W;

  step_e           kind;
  logic [XLEN-1:0] lo_sx;
  logic [XLEN-1:0] hi_zx;
  logic [XLEN-1:0] lui_val;

  always_comb begin
    lo_sx   = {{(XLEN-TGT_IMM_W){lo[TGT_IMM_W-1]}}, lo};
    hi_zx   = {{TGT_IMM_W{1'b0}}, hi};
    lui_val = XLEN'(ext[SRC_IMM_W-1:0]) << LUI_SH;
    if (len == 2'd1) begin
      kind = STEP_PASS;
    end else if (step == 2'd0) begin
      kind = STEP_UPPER;
    end else if (step == (len - 2'd1)) begin
      kind = STEP_FINAL;
    end else begin
      kind = STEP_MID;
    end
  end

  always_comb begin
    op  = TG_ADDI;
    rd  = '0;
    rs1 = '0;
    rs2 = '0;
    imm = '0;
    case (kind)
      STEP_PASS: begin
        if (src_op == SRC_LUI) begin
          op  = TG_LUI;
          rd  = rt;
          imm = lui_val;
        end else if (src_op == SRC_LOAD) begin
          op  = TG_LOAD;
          rd  = rt;
          rs1 = rs;
          imm = ext;
        end else if (src_op == SRC_STORE) begin
          op  = TG_STORE;
          rs1 = rs;
          rs2 = rt;
          imm = ext;
        end else begin
          op  = imm_form(src_op);
          rd  = rt;
          rs1 = rs;
          imm = ext;
        end
      end
      STEP_UPPER: begin
        op  = TG_LUI;
        rd  = tmp;
        imm = hi_zx;
      end
      STEP_MID: begin
        rd  = tmp;
        rs1 = tmp;
        if (is_mem_op(src_op)) begin
          op  = TG_ADD;
          rs2 = rs;
        end else begin
          op  = TG_ADDI;
          imm = lo_sx;
        end
      end
      default: begin
        if (src_op == SRC_LOAD) begin
          op  = TG_LOAD;
          rd  = rt;
          rs1 = tmp;
          imm = lo_sx;
        end else if (src_op == SRC_STORE) begin
          op  = TG_STORE;
          rs1 = tmp;
          rs2 = rt;
          imm = lo_sx;
        end else begin
          op  = reg_form(src_op);
          rd  = rt;
          rs1 = rs;
          rs2 = tmp;
        end
      end
    endcase
  end

endmodule

// File: rtl/imm_unfold.sv
module imm_unfold
  import imm_unfold_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int REG_W     = 5,
  parameter int SRC_IMM_W = 16,
  parameter int TGT_IMM_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [REG_W-1:0]     cfg_tmp_reg,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [XLEN-1:0]      in_pc,
  input  logic [3:0]           in_op,
  input  logic [REG_W-1:0]     in_rs,
  input  logic [REG_W-1:0]     in_rt,
  input  logic [SRC_IMM_W-1:0] in_imm,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [XLEN-1:0]      out_pc,
  output logic [3:0]           out_op,
  output logic [REG_W-1:0]     out_rd,
  output logic [REG_W-1:0]     out_rs1,
  output logic [REG_W-1:0]     out_rs2,
  output logic [XLEN-1:0]      out_imm,
  output logic                 out_last
);

  localparam int HI_W = XLEN - TGT_IMM_W;
  localparam logic signed [XLEN-1:0] IMM_MAX = XLEN'((1 << (TGT_IMM_W - 1)) - 1);
  localparam logic signed [XLEN-1:0] IMM_MIN = -IMM_MAX - XLEN'(1);

  logic [XLEN-1:0]      x_ext;
  logic [HI_W-1:0]      x_hi;
  logic [TGT_IMM_W-1:0] x_lo;
  logic [1:0]           x_len;

  logic                 take;
  logic                 busy;
  logic [1:0]           step;
  logic [1:0]           len;
  logic                 last;

  logic [XLEN-1:0]      h_pc;
  logic [3:0]           h_op;
  logic [REG_W-1:0]     h_rs;
  logic [REG_W-1:0]     h_rt;
  logic [REG_W-1:0]     h_tmp;
  logic [XLEN-1:0]      h_ext;
  logic [HI_W-1:0]      h_hi;
  logic [TGT_IMM_W-1:0] h_lo;

  imm_ext_split #(
    .XLEN(XLEN), .SRC_IMM_W(SRC_IMM_W), .TGT_IMM_W(TGT_IMM_W), .HI_W(HI_W)
  ) u_split (
    .op(in_op), .imm(in_imm), .ext(x_ext), .hi(x_hi), .lo(x_lo), .grp_len(x_len)
  );

  imm_unfold_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
    .in_len(x_len), .in_ready(in_ready), .take(take), .busy(busy),
    .step(step), .len(len), .last(last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_pc  <= '0;
      h_op  <= '0;
      h_rs  <= '0;
      h_rt  <= '0;
      h_tmp <= '0;
      h_ext <= '0;
      h_hi  <= '0;
      h_lo  <= '0;
    end else if (take) begin
      h_pc  <= in_pc;
      h_op  <= in_op;
      h_rs  <= in_rs;
      h_rt  <= in_rt;
      h_tmp <= cfg_tmp_reg;
      h_ext <= x_ext;
      h_hi  <= x_hi;
      h_lo  <= x_lo;
    end
  end

  imm_word_gen #(
    .XLEN(XLEN), .REG_W(REG_W), .SRC_IMM_W(SRC_IMM_W),
    .TGT_IMM_W(TGT_IMM_W), .HI_W(HI_W)
  ) u_gen (
    .step(step), .len(len), .src_op(h_op), .rs(h_rs), .rt(h_rt),
    .tmp(h_tmp), .ext(h_ext), .hi(h_hi), .lo(h_lo),
    .op(out_op), .rd(out_rd), .rs1(out_rs1), .rs2(out_rs2), .imm(out_imm)
  );

  assign out_valid = busy;
  assign out_pc    = h_pc;
  assign out_last  = last;

  AST_IDLE_ACCEPTS: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R1

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_op) && $stable(out_rd) &&
      $stable(out_rs1) && $stable(out_rs2) && $stable(out_imm) && $stable(out_pc))); // R9

  AST_BLOCK_MIDGROUP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |-> !in_ready); // R9

  AST_PC_KEPT_IN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=> (out_valid && $stable(out_pc))); // R8

  AST_EARLY_WORDS_TO_TMP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |-> (out_rd == h_tmp)); // R5

  AST_IMM_IN_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_op != TG_LUI) && ((out_op <= TG_XORI) || (out_op >= TG_LOAD)))
      |-> (($signed(out_imm) >= IMM_MIN) && ($signed(out_imm) <= IMM_MAX))); // R7

  AST_UPPER_IN_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_op == TG_LUI)) |-> (out_imm[XLEN-1:HI_W] == '0)); // R7

endmodule

// File: tb/sim_imm_unfold.sv
module sim_imm_unfold;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  cfg_tmp_reg = 5'd24;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_pc = '0;
  logic [3:0]  in_op = '0;
  logic [4:0]  in_rs = '0;
  logic [4:0]  in_rt = '0;
  logic [15:0] in_imm = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_pc;
  logic [3:0]  out_op;
  logic [4:0]  out_rd;
  logic [4:0]  out_rs1;
  logic [4:0]  out_rs2;
  logic [31:0] out_imm;
  logic        out_last;

  always #5 clk = ~clk;

  imm_unfold u0 (
    .clk(clk), .rst_n(rst_n), .cfg_tmp_reg(cfg_tmp_reg),
    .in_valid(in_valid), .in_ready(in_ready), .in_pc(in_pc), .in_op(in_op),
    .in_rs(in_rs), .in_rt(in_rt), .in_imm(in_imm),
    .out_valid(out_valid), .out_ready(out_ready), .out_pc(out_pc),
    .out_op(out_op), .out_rd(out_rd), .out_rs1(out_rs1), .out_rs2(out_rs2),
    .out_imm(out_imm), .out_last(out_last)
  );

  typedef struct {
    logic [31:0] pc;
    logic [3:0]  op;
    logic [4:0]  rd;
    logic [4:0]  rs1;
    logic [4:0]  rs2;
    logic [31:0] imm;
    logic        last;
    string       tag;
  } wexp_t;

  typedef struct {
    logic [3:0]  op;
    logic [4:0]  rs;
    logic [4:0]  rt;
    logic [15:0] imm;
  } src_t;

  wexp_t       exq[$];
  src_t        srcq[$];
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;
  bit          mon_on = 1'b0;
  logic [31:0] regs[32];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push_exp(input logic [31:0] pc, input logic [3:0] op, input logic [4:0] rd,
                          input logic [4:0] rs1, input logic [4:0] rs2, input logic [31:0] imm,
                          input logic last, input string tag);
    wexp_t w;
    w.pc = pc; w.op = op; w.rd = rd; w.rs1 = rs1; w.rs2 = rs2;
    w.imm = imm; w.last = last; w.tag = tag;
    exq.push_back(w);
  endtask

  function automatic logic [31:0] extend(input logic [3:0] op, input logic [15:0] imm);
    if (op >= 4 && op <= 6) return {16'h0, imm};
    return {{16{imm[15]}}, imm};
  endfunction

  function automatic logic [3:0] iform(input logic [3:0] op);
    if (op <= 1) return 4'd1;
    return op;
  endfunction

  function automatic logic [3:0] rform(input logic [3:0] op);
    if (op <= 1) return 4'd7;
    return op + 4'd6;
  endfunction

  task automatic send(input logic [31:0] pc, input logic [3:0] op, input logic [4:0] rs,
                      input logic [4:0] rt, input logic [15:0] imm, input logic [4:0] tmp,
                      input bit scramble);
    logic [31:0] ext, lo, hi;
    bit          fits;
    src_t        s;
    string       sfx;
    ext  = extend(op, imm);
    fits = (op == 4'd7) || ($signed(ext) >= -2048 && $signed(ext) <= 2047);
    hi   = (ext + 32'h800) >> 12;
    lo   = ext - (hi << 12);
    sfx  = scramble ? " R10 R8" : " R8";
    @(negedge clk);
    cfg_tmp_reg = tmp;
    in_valid = 1'b1; in_pc = pc; in_op = op; in_rs = rs; in_rt = rt; in_imm = imm;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    s.op = op; s.rs = rs; s.rt = rt; s.imm = imm;
    srcq.push_back(s);
    if (fits) begin
      if (op == 4'd7)      push_exp(pc, 4'd0, rt, 5'd0, 5'd0, {12'h0, imm, 4'h0}, 1'b1, {"R3", sfx});
      else if (op == 4'd8) push_exp(pc, 4'd13, rt, rs, 5'd0, ext, 1'b1, {"R2", sfx});
      else if (op == 4'd9) push_exp(pc, 4'd14, 5'd0, rs, rt, ext, 1'b1, {"R2", sfx});
      else                 push_exp(pc, iform(op), rt, rs, 5'd0, ext, 1'b1, {"R2", sfx});
    end else if (op >= 4'd8) begin
      push_exp(pc, 4'd0, tmp, 5'd0, 5'd0, hi, 1'b0, {"R4 R6", sfx});
      push_exp(pc, 4'd7, tmp, tmp, rs, 32'h0, 1'b0, {"R6", sfx});
      if (op == 4'd8) push_exp(pc, 4'd13, rt, tmp, 5'd0, lo, 1'b1, {"R6", sfx});
      else            push_exp(pc, 4'd14, 5'd0, tmp, rt, lo, 1'b1, {"R6", sfx});
    end else begin
      push_exp(pc, 4'd0, tmp, 5'd0, 5'd0, hi, 1'b0, {"R4 R5", sfx});
      if (lo != 0) push_exp(pc, 4'd1, tmp, tmp, 5'd0, lo, 1'b0, {"R4 R5", sfx});
      push_exp(pc, rform(op), rt, rs, tmp, 32'h0, 1'b1, {"R5", sfx});
    end
    if (scramble) begin
      #1;
      cfg_tmp_reg = ~tmp;
    end
  endtask

  function automatic logic [31:0] src_effect(input src_t s);
    logic [31:0] e, a;
    e = extend(s.op, s.imm);
    a = regs[s.rs];
    case (s.op)
      4'd2:    return {31'h0, $signed(a) < $signed(e)};
      4'd3:    return {31'h0, a < e};
      4'd4:    return a & e;
      4'd5:    return a | e;
      4'd6:    return a ^ e;
      4'd7:    return {s.imm, 16'h0};
      default: return a + e;
    endcase
  endfunction

  logic [31:0] snap_pc, snap_imm;
  logic [3:0]  snap_op;
  logic [4:0]  snap_rd;
  bit          was_stalled = 1'b0;
  bit          grp_start = 1'b1;
  logic [31:0] exp_eff;

  initial begin : monitor
    logic [31:0] a, b, val;
    wexp_t       w;
    src_t        s;
    wait (mon_on);
    forever begin
      @(negedge clk);
      out_ready = ($urandom_range(0, 3) != 0);
      #2;
      if (was_stalled) begin
        check(out_valid && out_pc == snap_pc && out_op == snap_op && out_rd == snap_rd &&
              out_imm == snap_imm, "R9 stall hold", {out_op, out_imm}, {snap_op, snap_imm});
      end
      was_stalled = out_valid && !out_ready;
      snap_pc = out_pc; snap_op = out_op; snap_rd = out_rd; snap_imm = out_imm;
      if (out_valid && !out_last) begin
        check(!in_ready, "R9 input blocked mid-group", in_ready, 1'b0);
      end
      if (out_valid && out_ready) begin
        if (exq.size() == 0) begin
          check(1'b0, "R8 unexpected word", out_pc, 0);
        end else begin
          w = exq.pop_front();
          check(out_pc == w.pc && out_op == w.op && out_rd == w.rd && out_rs1 == w.rs1 &&
                out_rs2 == w.rs2 && out_imm == w.imm && out_last == w.last, w.tag,
                {out_op, out_rd, out_rs1, out_rs2, out_imm, out_last},
                {w.op, w.rd, w.rs1, w.rs2, w.imm, w.last});
        end
        if (out_op == 4'd0) begin
          check(out_imm < 32'h100000, "R7 upper range", out_imm, 32'hFFFFF);
        end else if (out_op <= 4'd6 || out_op >= 4'd13) begin
          check($signed(out_imm) >= -2048 && $signed(out_imm) <= 2047, "R7 imm range", out_imm, 0);
        end
        if (grp_start && srcq.size() != 0) exp_eff = src_effect(srcq[0]);
        grp_start = out_last;
        a = regs[out_rs1];
        b = regs[out_rs2];
        val = 32'h0;
        case (out_op)
          4'd0:  val = out_imm << 12;
          4'd1:  val = a + out_imm;
          4'd2:  val = {31'h0, $signed(a) < $signed(out_imm)};
          4'd3:  val = {31'h0, a < out_imm};
          4'd4:  val = a & out_imm;
          4'd5:  val = a | out_imm;
          4'd6:  val = a ^ out_imm;
          4'd7:  val = a + b;
          4'd8:  val = {31'h0, $signed(a) < $signed(b)};
          4'd9:  val = {31'h0, a < b};
          4'd10: val = a & b;
          4'd11: val = a | b;
          4'd12: val = a ^ b;
          default: val = a + out_imm;
        endcase
        if (out_op <= 4'd12 && out_rd != 0) regs[out_rd] = val;
        if (out_last && srcq.size() != 0) begin
          s = srcq.pop_front();
          check(val == exp_eff, "R11 register effect", val, exp_eff);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : driver
    logic [15:0] bnd[7];
    logic [31:0] pc;
    bnd[0] = 16'h7FFF; bnd[1] = 16'h8000; bnd[2] = 16'h0800; bnd[3] = 16'hF800;
    bnd[4] = 16'h07FF; bnd[5] = 16'hFFFF; bnd[6] = 16'h0000;
    for (int i = 0; i < 32; i++) regs[i] = (i == 0) ? 32'h0 : $urandom;
    pc = 32'h0040_0000;
    repeat (3) @(negedge clk);
    check(!out_valid && in_ready, "R1 in reset", {out_valid, in_ready}, 2'b01);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    check(!out_valid && in_ready, "R1 after reset", {out_valid, in_ready}, 2'b01);
    mon_on = 1'b1;
    for (int op = 0; op < 10; op++) begin
      for (int k = 0; k < 7; k++) begin
        send(pc, 4'(op), 5'($urandom_range(0, 23)), 5'($urandom_range(1, 23)), bnd[k], 5'd24, 1'b0);
        pc += 4;
      end
    end
    for (int op = 0; op < 10; op++) begin
      send(pc, 4'(op), 5'($urandom_range(0, 23)), 5'($urandom_range(1, 23)), 16'h8001, 5'd30, 1'b1);
      pc += 4;
    end
    for (int n = 0; n < 300; n++) begin
      send(pc, 4'($urandom_range(0, 9)), 5'($urandom_range(0, 23)), 5'($urandom_range(1, 23)),
           ($urandom_range(0, 1) != 0) ? bnd[$urandom_range(0, 6)] : 16'($urandom),
           ($urandom_range(0, 1) != 0) ? 5'd24 : 5'd30, 1'b0);
      pc += 4;
    end
    @(negedge clk);
    in_valid = 1'b0;
    for (int t = 0; t < 2000 && (exq.size() != 0 || srcq.size() != 0); t++) @(negedge clk);
    check(exq.size() == 0, "R8 all words drained", exq.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule